// File: doc/BRIEF.md
# Quadrature Position Counter

This block turns two encoder lines, A and B, into a 32-bit position. A two-bit source field picks how the lines are read. The first choice is full x4 quadrature decoding. The second is pulse-plus-direction, where A carries the pulses and B sets the direction. The last two count only up or only down on A. In the up-only and down-only modes, one further bit chooses whether both edges of A count or only its rising edges.

Software uses a simple register port to write and read four registers: position, ceiling, decoder control and main control. A position load is accepted only when the value is at or below the ceiling. Counting wraps between 0 and the ceiling. Both encoder lines pass through a two-flop synchroniser before edge detection, so the counter can move by at most one step per clock.

Top module: `qpos_counter`

## Requirements
- R1: After reset, position reads 0, ceiling reads 0xFFFFFFFF, and decoder control and main control read 0. Addresses are: 0 position, 1 ceiling, 2 decoder control, 3 main control.
- R2: When decoder control bits 15:14 are 0 (quadrature), every edge of A and of B counts once. Taking the state as {A,B}, the order 00, 01, 11, 10 (B leading) counts up, and the reverse order counts down.
- R3: In quadrature mode, a sample in which A and B both change leaves the position unchanged.
- R4: When bits 15:14 are 1 (direction-count), only rising edges of A count. B high counts up, B low counts down, and edges of B alone do nothing.
- R5: When bits 15:14 are 2 (up-count), A increments the position and B has no effect. With decoder control bit 11 at 0, only rising edges of A count. With bit 11 at 1, both edges count.
- R6: When bits 15:14 are 3 (down-count), A decrements the position with the same bit-11 edge selection, and B has no effect.
- R7: Main control bit 3 enables counting. While it is 0, the position holds its value through any encoder activity.
- R8: A write to the position register takes effect on the next clock only if the value is not greater than the ceiling. Otherwise the write is dropped.
- R9: Counting up from the ceiling gives 0. Counting down from 0 gives the ceiling.
- R10: An encoder change driven before clock edge k shows in the position after edge k+2 and not before. The position changes by at most one step per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder line A (asynchronous) |
| enc_b | input | 1 | Encoder line B (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| pos_out | output | 32 | Current position |

## Verification
Two cases are hard to reach from the ports. The first is a quadrature sample in which both lines change at once. The second is a mode change that happens while A is already high, where a stale edge could count by mistake. The stimulus table drives A and B together in one step to produce the illegal transition. It also rewrites the decoder control between steps while the synchronised line state is held, so each mode starts from a known previous sample. Wrap-around uses a lowered ceiling, so both wrap directions occur within a few steps. The load-rejection case is placed right at the ceiling boundary.

// File: rtl/qpos_pkg.sv
package qpos_pkg;
  typedef enum logic [1:0] {
    SRC_QUAD = 2'd0,
    SRC_DIR  = 2'd1,
    SRC_UP   = 2'd2,
    SRC_DOWN = 2'd3
  } src_e;

  localparam int ADDR_W   = 2;
  localparam logic [ADDR_W-1:0] ADDR_POS  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CEIL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DEC  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTL  = 2'd3;

  localparam int SRC_LSB  = 14;
  localparam int EDGE_BIT = 11;
  localparam int EN_BIT   = 3;
endpackage

// File: rtl/qpos_sync.sv
module qpos_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prv_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= '0;
        else        stg_q[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= '0;
        else        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv_q <= '0;
    else        prv_q <= stg_q[STAGES-1];
  end

  assign cur  = stg_q[STAGES-1];
  assign prev = prv_q;
endmodule

// File: rtl/qpos_decode.sv
module qpos_decode
  import qpos_pkg::*;
(
  input  src_e       src,
  input  logic       both_edges,
  input  logic [1:0] cur,   // {A,B}
  input  logic [1:0] prev,  // {A,B}
  output logic       inc,
  output logic       dec
);
  logic a_chg, b_chg, a_rise, a_evt;

  always_comb begin
    a_chg  = cur[1] ^ prev[1];
    b_chg  = cur[0] ^ prev[0];
    a_rise = cur[1] & ~prev[1];
    a_evt  = both_edges ? a_chg : a_rise;
    inc    = 1'b0;
    dec    = 1'b0;
    unique case (src)
      SRC_QUAD: if (a_chg ^ b_chg) begin
        if (prev[1] ^ cur[0]) inc = 1'b1;
        else                  dec = 1'b1;
      end
      SRC_DIR: if (a_rise) begin
        if (cur[0]) inc = 1'b1;
        else        dec = 1'b1;
      end
      SRC_UP:   inc = a_evt;
      SRC_DOWN: dec = a_evt;
      default: ;
    endcase
  end
endmodule

// File: rtl/qpos_poscnt.sv
module qpos_poscnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         inc,
  input  logic         dec,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] ceil,
  output logic [W-1:0] pos
);
  logic [W-1:0] pos_q, pos_d;
  logic         pos_ce;

  always_comb begin
    pos_d  = pos_q;
    pos_ce = 1'b0;
    if (ld && (ld_val <= ceil)) begin
      pos_d  = ld_val;
      pos_ce = 1'b1;
    end else if (en && inc) begin
      pos_d  = (pos_q >= ceil) ? '0 : pos_q + 1'b1;
      pos_ce = 1'b1;
    end else if (en && dec) begin
      pos_d  = (pos_q == '0) ? ceil : pos_q - 1'b1;
      pos_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_ce) pos_q <= pos_d;
  end

  assign pos = pos_q;
endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
  import qpos_pkg::*;
#(
  parameter int POS_W       = 32,
  parameter int CTL_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [POS_W-1:0]  wr_data,
  input  logic [1:0]        rd_addr,
  output logic [POS_W-1:0]  rd_data,
  output logic [POS_W-1:0]  pos_out
);
  localparam int PAD_W = POS_W - CTL_W;

  logic [POS_W-1:0] ceil_q, ceil_d;
  logic [CTL_W-1:0] dec_q, dec_d, ctl_q, ctl_d;
  logic             ceil_ce, dec_ce, ctl_ce, pos_ld;
  logic [1:0]       ab_cur, ab_prev;
  logic             cnt_inc, cnt_dec;
  src_e             src;

  qpos_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({enc_a, enc_b}),
    .cur(ab_cur), .prev(ab_prev)
  );

  assign src = src_e'(dec_q[SRC_LSB +: 2]);

  qpos_decode u_dec (
    .src(src), .both_edges(dec_q[EDGE_BIT]),
    .cur(ab_cur), .prev(ab_prev),
    .inc(cnt_inc), .dec(cnt_dec)
  );

  assign pos_ld = wr_en && (wr_addr == ADDR_POS);

  qpos_poscnt #(.W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .en(ctl_q[EN_BIT]),
    .inc(cnt_inc), .dec(cnt_dec),
    .ld(pos_ld), .ld_val(wr_data), .ceil(ceil_q),
    .pos(pos_out)
  );

  always_comb begin
    ceil_ce = wr_en && (wr_addr == ADDR_CEIL);
    dec_ce  = wr_en && (wr_addr == ADDR_DEC);
    ctl_ce  = wr_en && (wr_addr == ADDR_CTL);
    ceil_d  = wr_data;
    dec_d   = wr_data[CTL_W-1:0];
    ctl_d   = wr_data[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ceil_q <= '1;
      dec_q  <= '0;
      ctl_q  <= '0;
    end else begin
      if (ceil_ce) ceil_q <= ceil_d;
      if (dec_ce)  dec_q  <= dec_d;
      if (ctl_ce)  ctl_q  <= ctl_d;
    end
  end

  always_comb begin
    unique case (rd_addr)
      ADDR_POS:  rd_data = pos_out;
      ADDR_CEIL: rd_data = ceil_q;
      ADDR_DEC:  rd_data = {{PAD_W{1'b0}}, dec_q};
      default:   rd_data = {{PAD_W{1'b0}}, ctl_q};
    endcase
  end
endmodule

// File: rtl/qpos_chk.sv
module qpos_chk
  import qpos_pkg::*;
#(
  parameter int POS_W = 32,
  parameter int CTL_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [POS_W-1:0] wr_data,
  input logic [POS_W-1:0] pos,
  input logic [POS_W-1:0] ceil,
  input logic [CTL_W-1:0] ctl,
  input logic             inc,
  input logic             dec
);
  logic ld, en;
  assign ld = wr_en && (wr_addr == ADDR_POS);
  assign en = ctl[EN_BIT];

  // R8
  load_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && (wr_data <= ceil)) |=> (pos == $past(wr_data)));

  // R7
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ld) |=> $stable(pos));

  // R10
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> (pos == $past(pos) || pos == $past(pos) + 1'b1 ||
             pos == $past(pos) - 1'b1 || pos == '0 || pos == $past(ceil)));

  // R10
  one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inc, dec}));

  // R9
  wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && inc && !ld && pos >= ceil) |=> (pos == '0));

  // R9
  wrap_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dec && !inc && !ld && pos == '0) |=> (pos == $past(ceil)));
endmodule

bind qpos_counter qpos_chk #(.POS_W(POS_W), .CTL_W(CTL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .pos(pos_out), .ceil(ceil_q), .ctl(ctl_q),
  .inc(cnt_inc), .dec(cnt_dec)
);

// File: tb/qpos_counter_tb_top.sv
module qpos_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enc_a, enc_b, wr_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data, pos_out;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;

  always #5ns clk = ~clk;

  qpos_counter dut_i (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pos_out(pos_out)
  );

  // {mode[1:0], both_edges, a, b, expected position}
  localparam int NV = 22;
  localparam logic [36:0] TV [NV] = '{
    {2'd0,1'b0,1'b0,1'b1,32'd11}, // R2 B leads: up
    {2'd0,1'b0,1'b1,1'b1,32'd12}, // R2
    {2'd0,1'b0,1'b1,1'b0,32'd13}, // R2
    {2'd0,1'b0,1'b0,1'b0,32'd14}, // R2
    {2'd0,1'b0,1'b1,1'b0,32'd13}, // R2 A leads: down
    {2'd0,1'b0,1'b0,1'b1,32'd13}, // R3 both change: ignored
    {2'd0,1'b0,1'b0,1'b0,32'd12}, // R2 down
    {2'd1,1'b0,1'b0,1'b1,32'd12}, // R4 B alone: none
    {2'd1,1'b0,1'b1,1'b1,32'd13}, // R4 rise, B high: up
    {2'd1,1'b0,1'b0,1'b1,32'd13}, // R4 fall: none
    {2'd1,1'b0,1'b0,1'b0,32'd13}, // R4 B alone: none
    {2'd1,1'b0,1'b1,1'b0,32'd12}, // R4 rise, B low: down
    {2'd2,1'b0,1'b0,1'b0,32'd12}, // R5 fall, rising only
    {2'd2,1'b0,1'b1,1'b0,32'd13}, // R5 rise
    {2'd2,1'b0,1'b1,1'b1,32'd13}, // R5 B ignored
    {2'd2,1'b0,1'b0,1'b1,32'd13}, // R5 fall not counted
    {2'd2,1'b1,1'b1,1'b1,32'd14}, // R5 both edges
    {2'd2,1'b1,1'b0,1'b1,32'd15}, // R5 both edges
    {2'd3,1'b0,1'b1,1'b0,32'd14}, // R6 rise
    {2'd3,1'b0,1'b0,1'b0,32'd14}, // R6 fall not counted
    {2'd3,1'b1,1'b1,1'b0,32'd13}, // R6 both edges
    {2'd3,1'b1,1'b0,1'b0,32'd12}  // R6 both edges
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1ns;
    d = rd_data;
  endtask

  task automatic drive(input logic a, input logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [15:0] cur_dec;
    rst_n = 1'b0; enc_a = 1'b0; enc_b = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 position", v, 32'h0);
    rd(2'd1, v); chk("R1 ceiling", v, 32'hFFFF_FFFF);
    rd(2'd2, v); chk("R1 decoder ctl", v, 32'h0);
    rd(2'd3, v); chk("R1 main ctl", v, 32'h0);

    wr(2'd3, 32'h8);
    wr(2'd0, 32'd10);
    chk("R8 load 10", pos_out, 32'd10);

    cur_dec = 16'h0;
    for (int i = 0; i < NV; i++) begin
      logic [15:0] want;
      want = {TV[i][36:35], 2'b00, TV[i][34], 11'b0};
      if (want != cur_dec) begin
        wr(2'd2, {16'h0, want});
        cur_dec = want;
      end
      drive(TV[i][33], TV[i][32]);
      chk($sformatf("R2-6 step %0d", i), pos_out, TV[i][31:0]);
    end

    // R8 load boundary against ceiling
    wr(2'd1, 32'd20);
    wr(2'd0, 32'd21);
    chk("R8 over ceiling dropped", pos_out, 32'd12);
    wr(2'd0, 32'd20);
    chk("R8 at ceiling accepted", pos_out, 32'd20);

    // R9 wrap up
    wr(2'd2, 32'h8000);
    drive(1'b1, 1'b0);
    chk("R9 wrap up", pos_out, 32'd0);

    // R10 latency
    drive(1'b0, 1'b0);
    @(negedge clk);
    enc_a = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 not yet", pos_out, 32'd0);
    @(negedge clk);
    chk("R10 after third edge", pos_out, 32'd1);

    // R9 wrap down
    wr(2'd0, 32'd0);
    wr(2'd2, 32'hC000);
    drive(1'b0, 1'b0);
    chk("R6 fall ignored", pos_out, 32'd0);
    drive(1'b1, 1'b0);
    chk("R9 wrap down", pos_out, 32'd20);

    // R7 disabled holds
    wr(2'd3, 32'h0);
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b0);
    chk("R7 hold", pos_out, 32'd20);
    rd(2'd3, v); chk("R7 ctl readback", v, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule